// File: doc/BRIEF.md
# Compact-ISA Arithmetic/Logic Unit with Flag Register

This block is the data-path core of a small processor that runs a dense 16-bit instruction encoding. It takes two operands and an operation code. It forms the result in combinational logic and reports whether that result should be written back. It also drives a per-operation mask that says which of the four condition flags (negative, zero, carry, overflow) the operation is allowed to change. The flags themselves are held in a register inside the block. Add-with-carry and subtract-with-carry read the stored carry.

The block covers moves, the bitwise operations, add and subtract (with and without carry), negate, and the three operations that set flags but discard their value: bit test, compare and compare-negative. Moves and adds that target the upper register bank get their own operation codes. Those codes write a result and touch no flag. Shifts, multiply, decode, the register file and memory access belong to other blocks.

The flag register loads only in a cycle where the update strobe is high. Even then, only the bits selected by the mask change. Everything else is plain control with no handshake. The caller presents an operation and holds it for one cycle.

Top module: `cmpct_alu`

## Requirements
- R1: After reset the flag output is all zero.
- R2: When `flag_upd_i` is low at a clock edge, the flag output does not change, whatever the operation.
- R3: Bitwise ops: 2 gives NOT b, 3 gives a AND b, 4 gives a AND NOT b, 5 gives a OR b, 6 gives a XOR b. Op 0 (immediate move) gives b. All six update only N and Z (mask 4'b1100). C and V keep their old values.
- R4: Op 1 (low-bank register move) gives b. It updates all four flags, with N and Z taken from the result and C and V cleared.
- R5: Op 8 (add) gives a+b and op 9 (add with carry) gives a+b+C. Op 14 (compare-negative) computes a+b. For all three, C is the carry out of the top bit and V is signed overflow. All four flags are updated.
- R6: Op 10 (subtract) gives a-b and op 11 gives a-b-(NOT C). Op 12 (negate) gives 0-b and op 13 (compare) computes a-b. For all four, C is 1 exactly when no borrow occurs and V is signed overflow. All four flags are updated.
- R7: `wr_en_o` is 0 for ops 7 (bit test: a AND b, mask N,Z), 13 and 14. It is 1 for every other defined operation.
- R8: Op 15 (upper-bank move, result b) and op 16 (upper-bank add, result a+b) write a result and have an all-zero mask, so no flag changes.
- R9: Flags and masks are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. N is the result's top bit and Z is set when the result is all zero. On an enabled update, each flag bit takes its new value where the mask is 1 and keeps its old value where the mask is 0.
- R10: Op codes 17 to 31 are undefined. They give result 0, `wr_en_o` 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| flag_upd_i | input | 1 | Flag update strobe |
| result_o | output | WIDTH | Computed value |
| wr_en_o | output | 1 | Result should be written back |
| upd_mask_o | output | 4 | Flags this operation may change (N,Z,C,V) |
| flags_o | output | 4 | Registered flags (N,Z,C,V) |

## Verification
The bench builds the block with WIDTH = 4. At that width every operand pair, both incoming carry values and all 32 operation codes can be swept completely. Every signed-overflow boundary, every borrow and carry-out case, and the all-zero result are therefore hit directly, including the undefined codes. Before each operation the flags are preloaded to a known value through the block's own ports. Some cases are repeated with the strobe held low to show the register holds its value.

// File: rtl/cmpct_alu_pkg.sv
package cmpct_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_MOVI = 5'd0,  OP_MOVR = 5'd1,  OP_MVN  = 5'd2,  OP_AND  = 5'd3,
    OP_BIC  = 5'd4,  OP_ORR  = 5'd5,  OP_EOR  = 5'd6,  OP_TST  = 5'd7,
    OP_ADD  = 5'd8,  OP_ADC  = 5'd9,  OP_SUB  = 5'd10, OP_SBC  = 5'd11,
    OP_NEG  = 5'd12, OP_CMP  = 5'd13, OP_CMN  = 5'd14, OP_MOVH = 5'd15,
    OP_ADDH = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [3:0] MASK_NONE = 4'b0000;
  localparam logic [3:0] MASK_NZ   = 4'b1100;
  localparam logic [3:0] MASK_ALL  = 4'b1111;
endpackage

// File: rtl/cmpct_alu_logic.sv
module cmpct_alu_logic
  import cmpct_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      OP_MVN:          y = ~b;
      OP_AND, OP_TST:  y = a & b;
      OP_BIC:          y = a & ~b;
      OP_ORR:          y = a | b;
      OP_EOR:          y = a ^ b;
      default:         y = b;
    endcase
  end
endmodule

// File: rtl/cmpct_alu_adder.sv
module cmpct_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    {cout, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end
endmodule

// File: rtl/cmpct_alu_flag_reg.sv
module cmpct_alu_flag_reg
  import cmpct_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [3:0] mask,
  input  flags_t     nxt,
  output flags_t     q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (upd) q <= (mask & nxt) | (~mask & q);
  end

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));

  // R9
  masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
endmodule

// File: rtl/cmpct_alu.sv
module cmpct_alu
  import cmpct_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             flag_upd_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       upd_mask_o,
  output logic [3:0]       flags_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  flags_t           cur, nxt;
  logic [WIDTH-1:0] log_y, add_x, add_y, add_s, res;
  logic             add_ci, add_co, add_v, use_add, clr_cv;

  assign op = alu_op_e'(op_i);

  cmpct_alu_logic #(.WIDTH(WIDTH)) u_logic (.op(op), .a(a_i), .b(b_i), .y(log_y));

  cmpct_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .x(add_x), .y(add_y), .cin(add_ci), .sum(add_s), .cout(add_co), .ovf(add_v)
  );

  always_comb begin
    add_x      = a_i;
    add_y      = b_i;
    add_ci     = 1'b0;
    use_add    = 1'b0;
    clr_cv     = 1'b0;
    wr_en_o    = 1'b1;
    upd_mask_o = MASK_NONE;
    unique case (op)
      OP_MOVI, OP_MVN, OP_AND, OP_BIC, OP_ORR, OP_EOR: upd_mask_o = MASK_NZ;
      OP_TST: begin upd_mask_o = MASK_NZ; wr_en_o = 1'b0; end
      OP_MOVR: begin upd_mask_o = MASK_ALL; clr_cv = 1'b1; end
      OP_ADD: begin use_add = 1'b1; upd_mask_o = MASK_ALL; end
      OP_ADC: begin use_add = 1'b1; upd_mask_o = MASK_ALL; add_ci = cur.c; end
      OP_CMN: begin use_add = 1'b1; upd_mask_o = MASK_ALL; wr_en_o = 1'b0; end
      OP_SUB: begin use_add = 1'b1; upd_mask_o = MASK_ALL; add_y = ~b_i; add_ci = 1'b1; end
      OP_SBC: begin use_add = 1'b1; upd_mask_o = MASK_ALL; add_y = ~b_i; add_ci = cur.c; end
      OP_CMP: begin
        use_add = 1'b1; upd_mask_o = MASK_ALL; add_y = ~b_i; add_ci = 1'b1; wr_en_o = 1'b0;
      end
      OP_NEG: begin
        use_add = 1'b1; upd_mask_o = MASK_ALL; add_x = '0; add_y = ~b_i; add_ci = 1'b1;
      end
      OP_MOVH: ;
      OP_ADDH: use_add = 1'b1;
      default: wr_en_o = 1'b0;
    endcase
  end

  always_comb begin
    if (use_add) res = add_s;
    else if (op_i > 5'(OP_ADDH)) res = '0;
    else res = log_y;
    nxt.n = res[MSB];
    nxt.z = (res == '0);
    nxt.c = use_add ? add_co : 1'b0;
    nxt.v = use_add ? add_v : 1'b0;
    if (clr_cv) begin
      nxt.c = 1'b0;
      nxt.v = 1'b0;
    end
  end

  assign result_o = res;
  assign flags_o  = cur;

  cmpct_alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd_i), .mask(upd_mask_o), .nxt(nxt), .q(cur)
  );

  // R7
  always_comb begin
    if (op == OP_TST || op == OP_CMP || op == OP_CMN)
      no_write_on_compare_chk: assert (!wr_en_o);
  end

  // R4
  movr_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_i && op == OP_MOVR) |=> (!flags_o[1] && !flags_o[0]));

  // R3
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_i && (op inside {OP_MOVI, OP_MVN, OP_AND, OP_BIC, OP_ORR, OP_EOR, OP_TST}))
    |=> $stable(flags_o[1:0]));

  // R8
  high_ops_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MOVH || op == OP_ADDH) |=> $stable(flags_o));
endmodule

// File: tb/cmpct_alu_bench.sv
module cmpct_alu_bench;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         flag_upd_i = 1'b0;
  logic [W-1:0] result_o;
  logic         wr_en_o;
  logic [3:0]   upd_mask_o, flags_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmpct_alu #(.WIDTH(W)) u_cmpct_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_upd_i(flag_upd_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .upd_mask_o(upd_mask_o), .flags_o(flags_o)
  );

  function automatic string req_of(input int op);
    if (op == 1) return "R4";
    if (op <= 6) return "R3";
    if (op == 7) return "R7";
    if (op == 8 || op == 9 || op == 14) return "R5";
    if (op >= 10 && op <= 13) return "R6";
    if (op == 15 || op == 16) return "R8";
    return "R10";
  endfunction

  task automatic model(input int op, input int a, input int b, input int c,
                       output int r, output int we, output int mk, output int nf);
    int x, y, ci, s, co, v;
    bit arith;
    x = a; y = b; ci = 0; arith = 0; we = 1; mk = 0; r = 0;
    case (op)
      0: begin r = b; mk = 12; end
      1: begin r = b; mk = 15; end
      2: begin r = ~b & M; mk = 12; end
      3: begin r = a & b; mk = 12; end
      4: begin r = a & ~b & M; mk = 12; end
      5: begin r = a | b; mk = 12; end
      6: begin r = a ^ b; mk = 12; end
      7: begin r = a & b; mk = 12; we = 0; end
      8, 14, 16: begin arith = 1; mk = (op == 16) ? 0 : 15; we = (op == 14) ? 0 : 1; end
      9: begin arith = 1; mk = 15; ci = c; end
      10, 13: begin arith = 1; mk = 15; y = ~b & M; ci = 1; we = (op == 13) ? 0 : 1; end
      11: begin arith = 1; mk = 15; y = ~b & M; ci = c; end
      12: begin arith = 1; mk = 15; x = 0; y = ~b & M; ci = 1; end
      15: r = b;
      default: we = 0;
    endcase
    co = 0; v = 0;
    if (arith) begin
      s = x + y + ci;
      r = s & M;
      co = (s >> W) & 1;
      v = (((x ^ r) & (y ^ r)) >> (W - 1)) & 1;
    end
    nf = (((r >> (W - 1)) & 1) << 3) | ((r == 0 ? 1 : 0) << 2) | (co << 1) | v;
  endtask

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input int op, input int a, input int b, input bit upd);
    @(negedge clk);
    op_i = 5'(op); a_i = W'(a); b_i = W'(b); flag_upd_i = upd;
  endtask

  // preload flags to {N=0,Z=1,C=c,V=0}
  task automatic preload(input int c);
    if (c != 0) drive(13, 0, 0, 1'b1);
    else drive(1, 0, 0, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r, we, mk, nf, old, exp;
    repeat (3) @(negedge clk);
    // R1
    check(flags_o == 4'd0, "R1", "flags after reset", flags_o, 0);
    rst_n = 1'b1;
    for (int op = 0; op < 32; op++) begin
      for (int a = 0; a <= M; a++) begin
        for (int b = 0; b <= M; b++) begin
          for (int c = 0; c < 2; c++) begin
            preload(c);
            drive(op, a, b, 1'b1);
            old = 4 | (c << 1);
            model(op, a, b, c, r, we, mk, nf);
            #1;
            check(result_o == W'(r) && wr_en_o == 1'(we) && upd_mask_o == 4'(mk),
                  req_of(op), $sformatf("op%0d a%0d b%0d c%0d res/we/mask", op, a, b, c),
                  {result_o, 3'b0, wr_en_o, upd_mask_o}, (r << 8) | (we << 4) | mk);
            @(negedge clk);
            exp = (mk & nf) | (~mk & old & 15);
            // R9: merge of new and kept flag bits
            check(flags_o == 4'(exp), req_of(op), $sformatf("op%0d a%0d b%0d c%0d flags", op, a, b, c),
                  flags_o, exp);
            if (a == b && c == 1 && op < 17) begin
              // R2: negate of a nonzero value would change flags if latched
              old = flags_o;
              op_i = 5'd12; b_i = W'(1); flag_upd_i = 1'b0;
              @(negedge clk);
              check(flags_o == 4'(old), "R2", "flags held without strobe", flags_o, old);
            end
          end
        end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule